// File: doc/BRIEF.md
# Size-Aware Integer Micro-op ALU

This block is the integer execution stage for a micro-op pipeline. Each valid micro-op supplies a first source value and a second operand. The second operand is either a register value or a zero-extended 8-bit immediate. The micro-op also supplies an operation code, an operand size of one, two, four or eight bytes, the old destination value, the current condition flags and a mask of the flags it may write.

The block computes the result at the selected width. It merges that result into the old destination, so that destination bits above the width are kept. It then forms the new flag word, and registers the result and flags together with one cycle of latency.

A conditional move takes the outcome of a condition evaluated elsewhere as a single input. When the condition is false, the destination and the flags pass through unchanged.

Top module: `uop_int_alu`

## Requirements
- R1: The `size` input selects the operand width: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits and 3 is 64 bits. Only the low width bits of `result` take the computed value. All higher bits equal `old_dest`.
- R2: When `use_imm` is 1, operand 2 is `imm8` zero-extended to 64 bits. Otherwise operand 2 is `src2`.
- R3: Op code 0 (add) gives src1 + op2. Op code 1 (add with carry) gives src1 + op2 + CF, where CF is `flags_in[0]`. Both are computed modulo 2^width.
- R4: Op code 2 (subtract) gives src1 - op2. Op code 3 (subtract with borrow) gives src1 - op2 - CF. Their flags come from the addition src1 + ~op2 + carry-in, where the carry-in is 1 for subtract and ~CF for subtract with borrow. CF is then the borrow, which is the inverse of that addition's carry out of the top bit.
- R5: Op codes 4, 5 and 6 give AND, OR and XOR of src1 and op2. For these op codes an enabled CF or OF is written as 0.
- R6: The flag word has CF at bit 0, PF at bit 1, AF at bit 2, ZF at bit 3, SF at bit 4 and OF at bit 5.
  - For add-type op codes, CF is the carry out of the top bit of the width.
  - OF is the signed overflow of the addition.
  - ZF is 1 when the width-limited result is zero.
  - SF is the top bit of the result.
  - PF is 1 when the low result byte has an even number of ones.
  - AF is the carry into bit 4, inverted for subtract-type op codes. For logic op codes it is taken from src1 + op2.
- R7: A flag bit is written only when its bit in `flag_en` is 1. Every other flag bit keeps its `flags_in` value.
- R8: Op code 7 (conditional move) writes operand 2 at the width when `cond_true` is 1. When `cond_true` is 0, `result` equals `old_dest`. In both cases the flags equal `flags_in`.
- R9: A micro-op with `in_valid` high appears on `result`, `flags_out` and `out_valid` one clock later. When `in_valid` is low, `out_valid` drops and `result` and `flags_out` hold their values.
- R10: After reset, `out_valid`, `result` and `flags_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Micro-op present this cycle |
| op | input | 3 | Operation code |
| size | input | 2 | Operand width code |
| use_imm | input | 1 | Select immediate as operand 2 |
| src1 | input | 64 | First source value |
| src2 | input | 64 | Second source register value |
| imm8 | input | 8 | Immediate operand |
| old_dest | input | 64 | Current destination value |
| flags_in | input | 6 | Current condition flags |
| flag_en | input | 6 | Flags this micro-op may write |
| cond_true | input | 1 | Condition result for conditional move |
| out_valid | output | 1 | Registered result valid |
| result | output | 64 | Merged destination value |
| flags_out | output | 6 | New condition flags |

## Verification
The bench uses the default data width of 64. This is the only width at which all four operand sizes exist, so it makes the eight-byte carry and overflow out of bit 63 reachable, alongside the narrower merges. Random operands are biased toward zero, all ones and sign-boundary values. This puts carry-in and borrow at both extremes in reach at every size. Directed cases cover the conditional move with a false condition and an empty flag mask.

// File: rtl/uop_int_alu.sv
module uop_int_alu #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        op,
  input  logic [1:0]        size,
  input  logic              use_imm,
  input  logic [DATA_W-1:0] src1,
  input  logic [DATA_W-1:0] src2,
  input  logic [7:0]        imm8,
  input  logic [DATA_W-1:0] old_dest,
  input  logic [5:0]        flags_in,
  input  logic [5:0]        flag_en,
  input  logic              cond_true,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic [5:0]        flags_out
);
  localparam int CF = 0, PF = 1, AF = 2, ZF = 3, SF = 4, OF = 5;

  logic [DATA_W-1:0] op2, wmask, a, b, r, merged;
  logic [DATA_W:0]   sum;
  logic              is_sub, is_logic, is_mov, cin;
  logic              carry, sa, sb, sr;
  logic [5:0]        gen, next_flags;

  assign op2      = use_imm ? {{(DATA_W-8){1'b0}}, imm8} : src2;
  assign is_sub   = (op == 3'd2) || (op == 3'd3);
  assign is_logic = (op == 3'd4) || (op == 3'd5) || (op == 3'd6);
  assign is_mov   = (op == 3'd7);

  always_comb begin
    case (size)
      2'd0:    wmask = DATA_W'(8'hFF);
      2'd1:    wmask = DATA_W'(16'hFFFF);
      2'd2:    wmask = DATA_W'(32'hFFFF_FFFF);
      default: wmask = '1;
    endcase
  end

  always_comb begin
    case (op)
      3'd1:    cin = flags_in[CF];
      3'd2:    cin = 1'b1;
      3'd3:    cin = ~flags_in[CF];
      default: cin = 1'b0;
    endcase
  end

  assign a   = src1 & wmask;
  assign b   = (is_sub ? ~op2 : op2) & wmask;
  assign sum = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};

  always_comb begin
    case (op)
      3'd4:    r = a & op2;
      3'd5:    r = a | (op2 & wmask);
      3'd6:    r = a ^ (op2 & wmask);
      3'd7:    r = op2 & wmask;
      default: r = sum[DATA_W-1:0] & wmask;
    endcase
  end

  always_comb begin
    case (size)
      2'd0:    begin carry = sum[8];  sa = a[7];  sb = b[7];  sr = r[7];  end
      2'd1:    begin carry = sum[16]; sa = a[15]; sb = b[15]; sr = r[15]; end
      2'd2:    begin carry = sum[32]; sa = a[31]; sb = b[31]; sr = r[31]; end
      default: begin carry = sum[DATA_W]; sa = a[DATA_W-1]; sb = b[DATA_W-1]; sr = r[DATA_W-1]; end
    endcase
  end

  always_comb begin
    gen     = '0;
    gen[CF] = is_logic ? 1'b0 : (carry ^ is_sub);
    gen[OF] = is_logic ? 1'b0 : ((sa == sb) && (sr != sa));
    gen[ZF] = (r == '0);
    gen[SF] = sr;
    gen[PF] = ~^r[7:0];
    gen[AF] = a[4] ^ b[4] ^ sum[4] ^ is_sub;
  end

  assign next_flags = is_mov ? flags_in : ((flags_in & ~flag_en) | (gen & flag_en));
  assign merged     = (is_mov && !cond_true) ? old_dest : ((old_dest & ~wmask) | r);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags_out <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= merged;
        flags_out <= next_flags;
      end
    end
  end

  // R9
  valid_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(flags_out)));
  // R7
  flag_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (((flags_out ^ $past(flags_in)) & ~$past(flag_en)) == 6'd0));
  // R8
  mov_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_mov) |=> (flags_out == $past(flags_in)));
  // R5
  logic_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_logic && flag_en[CF]) |=> !flags_out[CF]);
  // R1
  byte_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size == 2'd0) |=> (result[DATA_W-1:8] == $past(old_dest[DATA_W-1:8])));
endmodule

// File: tb/uop_int_alu_test.sv
module uop_int_alu_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic [2:0]  op = 0;
  logic [1:0]  size = 0;
  logic        use_imm = 0;
  logic [63:0] src1 = 0, src2 = 0, old_dest = 0;
  logic [7:0]  imm8 = 0;
  logic [5:0]  flags_in = 0, flag_en = 0;
  logic        cond_true = 0;
  logic        out_valid;
  logic [63:0] result;
  logic [5:0]  flags_out;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uop_int_alu uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .size(size),
    .use_imm(use_imm), .src1(src1), .src2(src2), .imm8(imm8), .old_dest(old_dest),
    .flags_in(flags_in), .flag_en(flag_en), .cond_true(cond_true),
    .out_valid(out_valid), .result(result), .flags_out(flags_out));

  task automatic model(output logic [63:0] er, output logic [5:0] ef);
    int w = 8 << size;
    logic [63:0] m = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 1);
    logic [63:0] o2 = use_imm ? {56'd0, imm8} : src2;
    logic [63:0] x = src1 & m;
    logic [63:0] y, val;
    logic [64:0] s;
    logic c0, sub, lg, cy, ovf, aux, sgn;
    logic [5:0] g;
    sub = (op == 2) || (op == 3);
    lg  = (op >= 4) && (op <= 6);
    c0  = (op == 1) ? flags_in[0] : (op == 2) ? 1'b1 : (op == 3) ? !flags_in[0] : 1'b0;
    y   = sub ? (~o2 & m) : (o2 & m);
    s   = {1'b0, x} + {1'b0, y} + c0;
    case (op)
      4: val = x & y;
      5: val = x | y;
      6: val = x ^ y;
      7: val = o2 & m;
      default: val = s[63:0] & m;
    endcase
    cy  = s[w];
    sgn = val[w-1];
    ovf = (x[w-1] == y[w-1]) && (sgn != x[w-1]);
    aux = x[4] ^ y[4] ^ s[4];
    if (sub) begin cy = !cy; aux = !aux; end
    if (lg) begin cy = 0; ovf = 0; end
    g  = {ovf, sgn, (val == 0), aux, ~^val[7:0], cy};
    ef = (op == 7) ? flags_in : ((flags_in & ~flag_en) | (g & flag_en));
    er = (op == 7 && !cond_true) ? old_dest : ((old_dest & ~m) | val);
  endtask

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_for(logic [2:0] o);
    case (o)
      0, 1: return "R3";
      2, 3: return "R4";
      4, 5, 6: return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic run_one();
    logic [63:0] er; logic [5:0] ef;
    model(er, ef);
    in_valid = 1;
    @(posedge clk); #1;
    check("R9 out_valid", {63'd0, out_valid}, 64'd1);
    check({tag_for(op), "/R1 result"}, result, er);
    check({tag_for(op), "/R6/R7 flags"}, {58'd0, flags_out}, {58'd0, ef});
  endtask

  function automatic logic [63:0] pick();
    case ($urandom_range(0, 5))
      0: return 64'd0;
      1: return 64'hFFFF_FFFF_FFFF_FFFF;
      2: return 64'h8000_0000_8000_8080;
      3: return 64'h7FFF_FFFF_7FFF_7F7F;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    logic [63:0] hr; logic [5:0] hf;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    // R10
    check("R10 out_valid", {63'd0, out_valid}, 64'd0);
    check("R10 result", result, 64'd0);
    check("R10 flags", {58'd0, flags_out}, 64'd0);
    rst_n = 1;

    // R3 adc carry-in wraps all ones at every size
    for (int sz = 0; sz < 4; sz++) begin
      op = 1; size = sz[1:0]; use_imm = 0; src1 = '1; src2 = 0; flags_in = 6'd1;
      flag_en = 6'h3F; old_dest = 64'hA5A5_A5A5_A5A5_A5A5; run_one();
      // R4 sbb borrow from zero
      op = 3; src1 = 0; src2 = 0; flags_in = 6'd1; run_one();
    end
    // R2 immediate path
    op = 0; size = 3; use_imm = 1; imm8 = 8'hFF; src1 = 64'd1; src2 = '1; flag_en = 6'h3F; run_one();
    // R8 false condition
    op = 7; cond_true = 0; old_dest = 64'h1234_5678_9ABC_DEF0; flags_in = 6'h2A; run_one();
    // R7 empty mask
    op = 2; cond_true = 1; use_imm = 0; flag_en = 0; flags_in = 6'h15; run_one();

    for (int i = 0; i < 600; i++) begin
      op = $urandom_range(0, 7); size = $urandom_range(0, 3); use_imm = $urandom_range(0, 1);
      src1 = pick(); src2 = pick(); imm8 = $urandom; old_dest = {$urandom, $urandom};
      flags_in = $urandom; flag_en = ($urandom_range(0, 3) == 0) ? $urandom : 6'h3F;
      cond_true = $urandom_range(0, 1);
      run_one();
    end

    // R9 idle holds outputs
    hr = result; hf = flags_out;
    in_valid = 0; src1 = ~src1; op = 0;
    @(posedge clk); #1;
    check("R9 idle valid", {63'd0, out_valid}, 64'd0);
    check("R9 idle result", result, hr);
    check("R9 idle flags", {58'd0, flags_out}, {58'd0, hf});
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule